// File: doc/BRIEF.md
# Mains-Synchronised Capture Timer

This block is a general-purpose timer whose counter can run up or down and reloads itself automatically. A programmable prescaler sets how many input clocks pass between two counter advances. A debug-halt input freezes the prescaler and the counter while it is held.

A mains zero-crossing comparator output is brought into the clock domain through a two-flop synchroniser. It then serves as the capture trigger. The trigger can be a rising edge, a falling edge, a high level or a low level. On each trigger the current count is copied into a timestamp register, so firmware can measure the mains period and phase against the timer.

Software programs the block through a simple write port. Reading happens directly from the output ports: the count, the captured timestamp, the sticky update, capture and overcapture flags, and one interrupt line.

Top module: `zc_timer`

## Requirements
- R1: After reset the count, the captured value, all three flags and the interrupt are zero.
- R2: A prescaler value P makes the counter advance once every P+1 clocks while the run bit (CTRL bit 0) is set. The prescaler restarts from zero while the run bit is clear. In up mode (CTRL bit 1 = 0) the counter goes from the reload value to zero on its next advance.
- R3: In down mode (CTRL bit 1 = 1) the counter goes from zero to the reload value on its next advance, and otherwise decrements.
- R4: Every wrap sets the update flag. It stays set until a write to CLEAR (address 3) with bit 0 set. A wrap in the same cycle as that clear leaves the flag set.
- R5: While dbg_halt_i is high, neither the counter nor the prescaler changes. After release, counting resumes from where it stopped.
- R6: The zero-crossing input passes through two synchronising flops. For a trigger taken from an input change just before clock edge A, the count present after edge A+1 is written to the capture register at edge A+2.
- R7: CTRL bits 3:2 choose the trigger: 00 rising edge, 01 falling edge, 10 high level, 11 low level. Transitions and levels of the other kinds capture nothing.
- R8: A capture sets the capture flag. It stays set until a CLEAR write with bit 1 set, which also clears the overcapture flag. A capture arriving while the capture flag is set and no clear is in progress sets the overcapture flag. A capture in the same cycle as the clear leaves the capture flag set and the overcapture flag clear.
- R9: In level modes a capture happens only while the capture flag is clear. A held level therefore produces one capture per clear and never sets the overcapture flag.
- R10: irq_o is high when the update flag is set with CTRL bit 4 set, or when the capture flag is set with CTRL bit 5 set.
- R11: Register write addresses: 0 CTRL, 1 prescaler, 2 reload, 3 CLEAR, 4 count load. Each write takes effect at the clock edge that samples wr_en_i. A count load takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| zc_in_i | input | 1 | Asynchronous zero-crossing comparator output |
| dbg_halt_i | input | 1 | Debug halt, freezes counting |
| cnt_o | output | 32 | Current count |
| cap_val_o | output | 32 | Captured timestamp |
| upd_flag_o | output | 1 | Sticky wrap flag |
| cap_flag_o | output | 1 | Sticky capture flag |
| ovc_flag_o | output | 1 | Sticky overcapture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall on the same edge, and both pairs are tested. The first pair is a capture and a counter wrap. The bench waits until the count is two below a small reload value, then raises the zero-crossing input so that the synchronised edge lands on the wrapping edge. It expects the captured value to equal the reload value, the count to read zero and the update flag to be set. The second pair is a capture and a software clear of the capture flag. The bench times the CLEAR write to hit the capture edge and expects the capture flag to remain set, the new timestamp to be stored and the overcapture flag to stay clear.

// File: rtl/zc_timer_pkg.sv
package zc_timer_pkg;

  typedef enum logic [1:0] {
    ZC_RISE = 2'b00,
    ZC_FALL = 2'b01,
    ZC_HIGH = 2'b10,
    ZC_LOW  = 2'b11
  } zc_mode_e;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;

  typedef struct packed {
    logic     cap_ie;
    logic     upd_ie;
    zc_mode_e mode;
    logic     down;
    logic     run;
  } ctrl_t;

  function automatic logic is_level(zc_mode_e m);
    return (m == ZC_HIGH) || (m == ZC_LOW);
  endfunction

endpackage

// File: rtl/zc_prescaler.sv
module zc_prescaler #(
  parameter int unsigned PSC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             halt_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] acc_q;
  logic             reach;

  assign reach  = (acc_q >= psc_i);
  assign tick_o = run_i && !halt_i && reach;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (!run_i)  acc_q <= '0;
    else if (!halt_i) acc_q <= reach ? '0 : acc_q + 1'b1;
  end

  // R5
  psc_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && run_i) |=> (acc_q == $past(acc_q)));

endmodule

// File: rtl/zc_counter.sv
module zc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             down_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  function automatic logic at_limit(logic [CNT_W-1:0] c, logic [CNT_W-1:0] r, logic dn);
    return dn ? (c == '0) : (c == r);
  endfunction

  function automatic logic [CNT_W-1:0] step(logic [CNT_W-1:0] c, logic [CNT_W-1:0] r, logic dn);
    if (at_limit(c, r, dn)) return dn ? r : '0;
    return dn ? c - 1'b1 : c + 1'b1;
  endfunction

  assign adv    = tick_i && !halt_i;
  assign wrap_o = adv && at_limit(cnt_q, reload_i, down_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (adv)    cnt_q <= step(cnt_q, reload_i, down_i);
  end

  // R5
  cnt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !load_i) |=> (cnt_q == $past(cnt_q)));

  // R2
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !halt_i && !load_i && !down_i && cnt_q == reload_i) |=> (cnt_q == '0));

  // R3
  down_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !halt_i && !load_i && down_i && cnt_q == '0) |=> (cnt_q == $past(reload_i)));

endmodule

// File: rtl/zc_detect.sv
module zc_detect
  import zc_timer_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     zc_i,
  input  zc_mode_e mode_i,
  input  logic     flag_i,
  output logic     evt_o
);

  logic [2:0] sh_q;
  logic       lvl, prev, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], zc_i};
  end

  assign lvl  = sh_q[1];
  assign prev = sh_q[2];

  always_comb begin
    unique case (mode_i)
      ZC_RISE: hit = lvl && !prev;
      ZC_FALL: hit = !lvl && prev;
      ZC_HIGH: hit = lvl && !flag_i;
      ZC_LOW:  hit = !lvl && !flag_i;
      default: hit = 1'b0;
    endcase
  end

  assign evt_o = hit;

  // R6
  rise_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == ZC_RISE && evt_o) |-> $past(zc_i, 2));

  // R6
  fall_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == ZC_FALL && evt_o) |-> !$past(zc_i, 2));

endmodule

// File: rtl/zc_timer.sv
module zc_timer
  import zc_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              zc_in_i,
  input  logic              dbg_halt_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cap_val_o,
  output logic              upd_flag_o,
  output logic              cap_flag_o,
  output logic              ovc_flag_o,
  output logic              irq_o
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] reload_q, cap_q;
  logic             upd_q, capf_q, ovc_q;

  // named internal events
  logic tick, wrap, cap_evt, clr_upd, clr_cap, load_cnt, ovc_set, lvl_mode;

  assign clr_upd  = wr_en_i && (wr_addr_i == A_CLEAR) && wr_data_i[0];
  assign clr_cap  = wr_en_i && (wr_addr_i == A_CLEAR) && wr_data_i[1];
  assign load_cnt = wr_en_i && (wr_addr_i == A_COUNT);
  assign ovc_set  = cap_evt && capf_q && !clr_cap;
  assign lvl_mode = is_level(ctrl_q.mode);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      psc_q    <= '0;
      reload_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL)   ctrl_q   <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wr_addr_i == A_PSC)    psc_q    <= wr_data_i[PSC_W-1:0];
      if (wr_addr_i == A_RELOAD) reload_q <= wr_data_i[CNT_W-1:0];
    end
  end

  zc_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.run),
    .halt_i (dbg_halt_i),
    .psc_i  (psc_q),
    .tick_o (tick)
  );

  zc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .halt_i     (dbg_halt_i),
    .down_i     (ctrl_q.down),
    .load_i     (load_cnt),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .reload_i   (reload_q),
    .cnt_o      (cnt_o),
    .wrap_o     (wrap)
  );

  zc_detect u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .zc_i   (zc_in_i),
    .mode_i (ctrl_q.mode),
    .flag_i (capf_q),
    .evt_o  (cap_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q  <= 1'b0;
      capf_q <= 1'b0;
      ovc_q  <= 1'b0;
      cap_q  <= '0;
    end else begin
      if (wrap)         upd_q <= 1'b1;
      else if (clr_upd) upd_q <= 1'b0;
      if (cap_evt)      capf_q <= 1'b1;
      else if (clr_cap) capf_q <= 1'b0;
      if (ovc_set)      ovc_q <= 1'b1;
      else if (clr_cap) ovc_q <= 1'b0;
      if (cap_evt)      cap_q <= cnt_o;
    end
  end

  assign cap_val_o  = cap_q;
  assign upd_flag_o = upd_q;
  assign cap_flag_o = capf_q;
  assign ovc_flag_o = ovc_q;
  assign irq_o      = (upd_q && ctrl_q.upd_ie) || (capf_q && ctrl_q.cap_ie);

  // R6
  cap_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (cap_val_o == $past(cnt_o)));

  // R8
  cap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> cap_flag_o);

  // R8
  ovc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && cap_flag_o && !clr_cap) |=> ovc_flag_o);

  // R4
  upd_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> upd_flag_o);

  // R9
  lvl_no_ovc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_mode |-> !ovc_set);

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_state_chk: assert (!upd_q && !capf_q && !ovc_q);
    end
  end

endmodule

// File: tb/test_zc_timer.sv
module test_zc_timer;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        zc = 1'b0;
  logic        halt = 1'b0;
  logic [31:0] cnt, cap_val;
  logic        upd, capf, ovc, irq;

  int vectors = 0;
  int fails   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_timer i_zc_timer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .zc_in_i    (zc),
    .dbg_halt_i (halt),
    .cnt_o      (cnt),
    .cap_val_o  (cap_val),
    .upd_flag_o (upd),
    .cap_flag_o (capf),
    .ovc_flag_o (ovc),
    .irq_o      (irq)
  );

  // CTRL bits: 0 run, 1 down, 3:2 mode, 4 update irq enable, 5 capture irq enable
  localparam logic [31:0] RUN = 32'h1, DOWN = 32'h2, UIE = 32'h10, CIE = 32'h20;
  localparam logic [31:0] M_RISE = 32'h0, M_FALL = 32'h4, M_HIGH = 32'h8, M_LOW = 32'hC;

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", rq, got, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge; returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] ctrl, input logic [31:0] p, input logic [31:0] r);
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h0);
    wr(3'd1, p);
    wr(3'd2, r);
    wr(3'd3, 32'h3);
    wr(3'd0, ctrl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    cyc(3);
    // R1 reset state, held and just after release
    chk("R1 count", cnt, 0);
    chk("R1 flags", {29'd0, upd, capf, ovc}, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 capture", cap_val, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 R4 R11 up count sweep
    for (int p = 0; p < 3; p++) begin
      for (int r = 0; r < 5; r++) begin
        setup(RUN, p, r);
        for (int t = 0; t < 2 * (p + 1) * (r + 1) + 3; t++) begin
          int k;
          k = t / (p + 1);
          chk("R2 up count", cnt, k % (r + 1));
          chk("R4 up update flag", {31'd0, upd}, (k >= r + 1) ? 1 : 0);
          cyc(1);
        end
      end
    end

    // R3 R4 down count sweep
    for (int p = 0; p < 3; p++) begin
      for (int r = 0; r < 5; r++) begin
        setup(RUN | DOWN, p, r);
        for (int t = 0; t < 2 * (p + 1) * (r + 1) + 3; t++) begin
          int k;
          k = t / (p + 1);
          chk("R3 down count", cnt, (r + 1 - (k % (r + 1))) % (r + 1));
          chk("R4 down update flag", {31'd0, upd}, (k >= 1) ? 1 : 0);
          cyc(1);
        end
      end
    end

    // R4 clear of update flag
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h1);
    chk("R4 update clear", {31'd0, upd}, 0);

    // R11 count load
    wr(3'd4, 32'd1234);
    chk("R11 count load", cnt, 1234);

    // R5 debug halt
    setup(RUN, 1, 100);
    cyc(6);
    halt = 1'b1;
    exp = cnt;
    cyc(8);
    chk("R5 halt freezes", cnt, exp);
    halt = 1'b0;
    cyc(2);
    chk("R5 resume", cnt, exp + 1);

    // R6 R7 rising edge capture
    setup(RUN | M_RISE, 0, 1000);
    cyc(4);
    zc = 1'b1;
    cyc(2);
    exp = cnt;
    cyc(1);
    chk("R6 rise capture value", cap_val, exp);
    chk("R8 capture flag", {31'd0, capf}, 1);
    wr(3'd3, 32'h2);
    zc = 1'b0;
    cyc(5);
    chk("R7 rise ignores fall", {31'd0, capf}, 0);

    // R7 falling edge mode
    wr(3'd0, RUN | M_FALL);
    zc = 1'b1;
    cyc(5);
    chk("R7 fall ignores rise", {31'd0, capf}, 0);
    zc = 1'b0;
    cyc(2);
    exp = cnt;
    cyc(1);
    chk("R7 fall capture value", cap_val, exp);
    chk("R7 fall capture flag", {31'd0, capf}, 1);
    wr(3'd3, 32'h2);

    // R7 R9 high level mode
    wr(3'd0, RUN | M_HIGH);
    cyc(4);
    chk("R7 high ignores low", {31'd0, capf}, 0);
    zc = 1'b1;
    cyc(2);
    exp = cnt;
    cyc(1);
    chk("R7 high capture value", cap_val, exp);
    cyc(3);
    chk("R9 held level no overcapture", {31'd0, ovc}, 0);
    chk("R9 held level no new capture", cap_val, exp);
    wr(3'd3, 32'h2);
    exp = cnt;
    cyc(1);
    chk("R9 recapture after clear", cap_val, exp);
    chk("R9 recapture flag", {30'd0, capf, ovc}, 2);
    zc = 1'b0;
    cyc(4);
    wr(3'd3, 32'h2);
    cyc(4);
    chk("R7 high released", {31'd0, capf}, 0);

    // R7 low level mode: input already low, capture follows the mode write
    wr(3'd0, RUN | M_LOW);
    exp = cnt;
    cyc(1);
    chk("R7 low capture value", cap_val, exp);
    chk("R7 low capture flag", {31'd0, capf}, 1);
    zc = 1'b1;
    cyc(4);
    wr(3'd3, 32'h2);
    cyc(4);
    chk("R7 low ignores high", {31'd0, capf}, 0);

    // R8 overcapture
    wr(3'd0, RUN | M_RISE);
    zc = 1'b0;
    cyc(4);
    wr(3'd3, 32'h2);
    zc = 1'b1; cyc(4);
    zc = 1'b0; cyc(4);
    zc = 1'b1; cyc(2);
    exp = cnt;
    cyc(1);
    chk("R8 overcapture flag", {31'd0, ovc}, 1);
    chk("R8 latest value kept", cap_val, exp);
    wr(3'd3, 32'h2);
    chk("R8 clear both", {30'd0, capf, ovc}, 0);

    // R8 capture on the same edge as the clear (flag already set)
    zc = 1'b0; cyc(4);
    zc = 1'b1; cyc(4);
    zc = 1'b0; cyc(4);
    chk("R8 preset flag", {31'd0, capf}, 1);
    zc = 1'b1;
    cyc(2);
    exp = cnt;
    wr(3'd3, 32'h2);
    chk("R8 set wins over clear", {30'd0, capf, ovc}, 2);
    chk("R8 same edge value", cap_val, exp);

    // R2 R6 capture on the wrap edge
    zc = 1'b0;
    setup(RUN | M_RISE, 0, 7);
    while (cnt != 5) cyc(1);
    zc = 1'b1;
    cyc(3);
    chk("R6 capture on wrap value", cap_val, 7);
    chk("R2 wrap count", cnt, 0);
    chk("R4 wrap with capture", {30'd0, upd, capf}, 3);

    // R10 interrupt gating
    zc = 1'b0;
    setup(RUN, 0, 0);
    cyc(2);
    chk("R10 flag set no irq", {30'd0, upd, irq}, 2);
    wr(3'd0, RUN | UIE);
    chk("R10 update irq", {31'd0, irq}, 1);
    wr(3'd0, CIE);
    wr(3'd3, 32'h3);
    chk("R10 irq clear", {31'd0, irq}, 0);
    zc = 1'b1;
    cyc(3);
    chk("R10 capture irq", {31'd0, irq}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule